// File: doc/BRIEF.md
# Masked-Write GPIO Port

A 32-pin general-purpose I/O port that sits behind a plain 32-bit register bus. The bus has an address, a write enable, write data and combinational read data. The port holds a direction mask, where a 1 makes the pin drive, and an output latch. It also brings the pad levels in through a synchronizer so software can read them.

Direction has one write-only address that sets bits and a second address that clears them. The output latch is split into a lower half and an upper half. Each half-word write carries a 16-bit enable mask in its upper bits and 16 new values in its lower bits, so any single pin changes without a read-modify-write sequence.

The output latch keeps its value while a pin is an input. Software can therefore load the level it wants before turning the pin around, and the pad drives that level from its first cycle as an output.

Top module: `gpio_mw_port`

## Requirements
- R1: After reset every pin is an input (`pad_oe` all 0) and every output latch bit is 0 (`pad_out` all 0).
- R2: A bus write to offset 0x00 turns pin n into an output for every data bit n that is 1, one cycle after the write. Bits written as 0 leave that pin's direction unchanged.
- R3: A bus write to offset 0x04 turns pin n into an input for every data bit n that is 1. Bits written as 0 leave that pin's direction unchanged.
- R4: A bus write to offset 0x08 updates latch bit n (n = 0..15) to data bit n only where data bit n+16 is 1. The other latch bits are unchanged.
- R5: A bus write to offset 0x0C updates latch bit 16+n (n = 0..15) to data bit n only where data bit n+16 is 1. The other latch bits are unchanged.
- R6: `pad_out` always shows the output latch, whatever the direction. The latch keeps its value while the pin is an input, so switching a pin to output drives the stored level in the same cycle that `pad_oe` rises.
- R7: Reading offset 0x10 returns `pad_in` delayed by two clock edges through a two-flop synchronizer.
- R8: Reading offset 0x04 returns the direction mask (1 = output). Reading 0x08 or 0x0C returns that half's 16 latch bits in bits 15:0, with bits 31:16 equal to 0.
- R9: A write to any offset other than 0x00, 0x04, 0x08 or 0x0C changes nothing. A read from any offset other than 0x04, 0x08, 0x0C or 0x10 (0x00 included) returns 0.
- R10: While `bus_we` is 0, neither the direction mask nor the latch changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| pad_in | input | 32 | Pad input levels, asynchronous |
| pad_oe | output | 32 | Pad output enable, one bit per pin |
| pad_out | output | 32 | Pad output value, one bit per pin |

## Verification
The assertions assume that the bus carries at most one write per cycle, to a single offset. They also assume that `bus_addr` and `bus_wdata` are stable around the clock edge. For the synchronizer check they assume that `pad_in` only changes between edges.

The bench drives every bus and pad input at the falling clock edge. It keeps each write to a single cycle and samples the outputs on the falling edge after the write edge, so every property is evaluated on clean, known values.

// File: rtl/gpio_mw_pkg.sv
package gpio_mw_pkg;
    localparam int PIN_W  = 32;
    localparam int HALF_W = PIN_W / 2;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_DIR_SET = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_DIR_CLR = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_OUT_LO  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_OUT_HI  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_LEVEL   = 8'h10;
endpackage

// File: rtl/gpio_mw_dir_reg.sv
module gpio_mw_dir_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] bits,
    output logic [W-1:0] dir_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dir_q <= '0;
        else if (set_en)
            dir_q <= dir_q | bits;
        else if (clr_en)
            dir_q <= dir_q & ~bits;
    end
endmodule

// File: rtl/gpio_mw_out_half.sv
module gpio_mw_out_half #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] val,
    output logic [W-1:0] lat_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            lat_q <= '0;
        else if (wr_en)
            lat_q <= (lat_q & ~mask) | (val & mask);
    end
endmodule

// File: rtl/gpio_mw_sync.sv
module gpio_mw_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++)
                stg[i] <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++)
                stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/gpio_mw_port.sv
module gpio_mw_port
    import gpio_mw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PIN_W-1:0]  pad_in,
    output logic [PIN_W-1:0]  pad_oe,
    output logic [PIN_W-1:0]  pad_out
);
    localparam int NHALF = PIN_W / HALF_W;

    logic              wr_set, wr_clr;
    logic [NHALF-1:0]  wr_half;
    logic [PIN_W-1:0]  dir_q;
    logic [PIN_W-1:0]  lat_q;
    logic [PIN_W-1:0]  lvl_q;

    assign wr_set     = bus_we && (bus_addr == OFS_DIR_SET);
    assign wr_clr     = bus_we && (bus_addr == OFS_DIR_CLR);
    assign wr_half[0] = bus_we && (bus_addr == OFS_OUT_LO);
    assign wr_half[1] = bus_we && (bus_addr == OFS_OUT_HI);

    gpio_mw_dir_reg #(.W(PIN_W)) dir_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (wr_set),
        .clr_en (wr_clr),
        .bits   (bus_wdata[PIN_W-1:0]),
        .dir_q  (dir_q)
    );

    for (genvar h = 0; h < NHALF; h++) begin : g_half
        gpio_mw_out_half #(.W(HALF_W)) half_i (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (wr_half[h]),
            .mask  (bus_wdata[2*HALF_W-1:HALF_W]),
            .val   (bus_wdata[HALF_W-1:0]),
            .lat_q (lat_q[h*HALF_W +: HALF_W])
        );
    end

    gpio_mw_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pad_in),
        .dout  (lvl_q)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_DIR_CLR: bus_rdata = dir_q;
            OFS_OUT_LO:  bus_rdata[HALF_W-1:0] = lat_q[HALF_W-1:0];
            OFS_OUT_HI:  bus_rdata[HALF_W-1:0] = lat_q[PIN_W-1:HALF_W];
            OFS_LEVEL:   bus_rdata = lvl_q;
            default:     bus_rdata = '0;
        endcase
    end

    assign pad_oe  = dir_q;
    assign pad_out = lat_q;
endmodule

// File: rtl/gpio_mw_port_chk.sv
module gpio_mw_port_chk
    import gpio_mw_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [PIN_W-1:0]  pad_in,
    input logic [PIN_W-1:0]  pad_oe,
    input logic [PIN_W-1:0]  pad_out
);
    logic [1:0] age;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    // R2
    dir_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_DIR_SET) |=> ((pad_oe & $past(bus_wdata)) == $past(bus_wdata)));
    // R3
    dir_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_DIR_CLR) |=> ((pad_oe & $past(bus_wdata)) == '0));
    // R10
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && (bus_addr == OFS_DIR_SET || bus_addr == OFS_DIR_CLR)) |=> $stable(pad_oe));
    // R4
    lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == OFS_OUT_LO) |=> $stable(pad_out[15:0]));
    // R5
    hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == OFS_OUT_HI) |=> $stable(pad_out[31:16]));
    // R4
    lo_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_OUT_LO) |=>
        ((pad_out[15:0] & ~$past(bus_wdata[31:16])) == ($past(pad_out[15:0]) & ~$past(bus_wdata[31:16]))));
    // R9
    undef_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_addr == OFS_DIR_CLR || bus_addr == OFS_OUT_LO ||
          bus_addr == OFS_OUT_HI || bus_addr == OFS_LEVEL) |-> (bus_rdata == '0));
    // R7
    level_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && bus_addr == OFS_LEVEL) |-> (bus_rdata == $past(pad_in, 2)));
    // R8
    hi_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_OUT_HI) |-> (bus_rdata[31:16] == 16'h0));
endmodule

bind gpio_mw_port gpio_mw_port_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out)
);

// File: tb/gpio_mw_port_tb_top.sv
module gpio_mw_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_oe;
    logic [31:0] pad_out;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    gpio_mw_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out)
    );

    typedef struct packed {
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp_oe;
        logic [31:0] exp_out;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t TBL [NV] = '{
        '{8'h00, 32'h0000_00FF, 32'h0000_00FF, 32'h0000_0000, 8'd2},  // R2
        '{8'h00, 32'hF000_0000, 32'hF000_00FF, 32'h0000_0000, 8'd2},  // R2
        '{8'h04, 32'h0000_000F, 32'hF000_00F0, 32'h0000_0000, 8'd3},  // R3
        '{8'h08, 32'h00FF_1234, 32'hF000_00F0, 32'h0000_0034, 8'd4},  // R4
        '{8'h08, 32'h0F00_FFFF, 32'hF000_00F0, 32'h0000_0F34, 8'd4},  // R4
        '{8'h0C, 32'hFFFF_ABCD, 32'hF000_00F0, 32'hABCD_0F34, 8'd5},  // R5
        '{8'h0C, 32'h8001_0000, 32'hF000_00F0, 32'h2BCC_0F34, 8'd5},  // R5
        '{8'h14, 32'hFFFF_FFFF, 32'hF000_00F0, 32'h2BCC_0F34, 8'd9},  // R9
        '{8'h10, 32'hFFFF_FFFF, 32'hF000_00F0, 32'h2BCC_0F34, 8'd9},  // R9
        '{8'h08, 32'h0000_FFFF, 32'hF000_00F0, 32'h2BCC_0F34, 8'd4},  // R4
        '{8'h04, 32'hFFFF_FFFF, 32'h0000_0000, 32'h2BCC_0F34, 8'd6}   // R6
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    initial begin
        logic [31:0] r;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 oe", pad_oe, 32'h0);
        check("R1 out", pad_out, 32'h0);
        rd(8'h04, r); check("R1 dir read", r, 32'h0);

        for (int i = 0; i < NV; i++) begin
            wr(TBL[i].addr, TBL[i].data);
            if (pad_oe !== TBL[i].exp_oe || pad_out !== TBL[i].exp_out) begin
                n_chk++; n_bad++;
                $display("FAIL R%0d row %0d actual oe=%h out=%h expected oe=%h out=%h",
                         TBL[i].req, i, pad_oe, pad_out, TBL[i].exp_oe, TBL[i].exp_out);
            end else n_chk++;
        end

        // R8 readback
        @(negedge clk);
        rd(8'h04, r); check("R8 dir", r, 32'h0);
        rd(8'h08, r); check("R8 lo", r, 32'h0000_0F34);
        rd(8'h0C, r); check("R8 hi", r, 32'h0000_2BCC);
        // R9 undefined reads
        rd(8'h00, r); check("R9 read 0x00", r, 32'h0);
        rd(8'h20, r); check("R9 read 0x20", r, 32'h0);

        // R6 preload then turn around
        wr(8'h08, 32'h0001_0001);
        check("R6 preload out", pad_out, 32'h2BCC_0F35);
        check("R6 still input", pad_oe, 32'h0);
        wr(8'h00, 32'h0000_0001);
        check("R6 oe rises", pad_oe, 32'h0000_0001);
        check("R6 drives level", pad_out, 32'h2BCC_0F35);

        // R10 no write strobe
        @(negedge clk);
        bus_addr = 8'h00; bus_wdata = 32'hFFFF_FFFF; bus_we = 1'b0;
        @(negedge clk);
        bus_addr = 8'h0C; bus_wdata = 32'hFFFF_0000;
        @(negedge clk);
        check("R10 oe", pad_oe, 32'h0000_0001);
        check("R10 out", pad_out, 32'h2BCC_0F35);
        bus_wdata = '0;

        // R7 two-stage sync
        bus_addr = 8'h10;
        pad_in = 32'hA5A5_5A5A;
        @(negedge clk);
        rd(8'h10, r); check("R7 after one edge", r, 32'h0);
        @(negedge clk);
        rd(8'h10, r); check("R7 after two edges", r, 32'hA5A5_5A5A);
        pad_in = 32'h0F0F_F0F0;
        @(negedge clk);
        @(negedge clk);
        rd(8'h10, r); check("R7 second pattern", r, 32'h0F0F_F0F0);

        // R1 reset mid-run
        rst_n = 1'b0;
        #2;
        check("R1 reset oe", pad_oe, 32'h0);
        check("R1 reset out", pad_out, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule